// File: doc/BRIEF.md
# Timer Interrupt Vector Arbiter

This block merges the interrupt events of a timer into one request line. The events come from two kinds of source. The first is capture/compare channels 1 through 4. The second is the counter overflow. Each source presents a pending flag and a local enable. A source whose flag and enable are both high is active. The request line is high while any source is active.

A processor services the request by reading the vector register. On the clock edge where the read strobe is sampled high, the block takes a snapshot of the active sources. From that snapshot it does two things:

- It latches a code that names the highest-ranked active source. The code appears on the vector output.
- In the following cycle, it drives a one-cycle clear pulse to that source's flag owner.

Because the code and the clear come from the same snapshot, each read retires exactly one event. An event that arrives after the snapshot stays pending.

Channel 0 has its own interrupt outside this block and ranks above all of these sources.

Top module: `tmr_irq_vector`

## Requirements
- R1: `irq` is high in the same cycle that any source has both its flag and its enable high, and low otherwise.
- R2: A source whose enable is low is ignored. Its flag does not raise `irq`, does not win a read and is never cleared.
- R3: Among active sources, channel 1 wins over channel 2, channel 2 over channel 3, channel 3 over channel 4, and channel 4 over the overflow.
- R4: The vector codes are 0x00 for no active source, 0x02 for channel 1, 0x04 for channel 2, 0x06 for channel 3, 0x08 for channel 4 and 0x0E for the overflow. Bit i of `chan_clr` belongs to channel i+1.
- R5: `vec` takes the winner's code on the rising edge where `rd_stb` is sampled high. It holds that value until the next such edge.
- R6: A read drives exactly one clear output high, for the single cycle after the sampling edge, and only for the source that won. A read with no active source produces no clear.
- R7: A flag that rises after the sampling edge of a read is not cleared by that read. It wins the next read if it ranks highest.
- R8: During reset and after it, `vec` is 0x00 and all clear outputs are low.
- R9: `irq` stays high after a read while any other enabled flag is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_flag | input | NCH | Pending flags of channels 1..NCH (bit 0 = channel 1) |
| chan_en | input | NCH | Local enables of channels 1..NCH |
| ovf_flag | input | 1 | Counter overflow pending flag |
| ovf_en | input | 1 | Counter overflow enable |
| rd_stb | input | 1 | One-cycle read strobe for the vector register |
| irq | output | 1 | Combined interrupt request |
| vec | output | VW | Code of the source retired by the last read |
| chan_clr | output | NCH | One-cycle clear pulses to the channel flags |
| ovf_clr | output | 1 | One-cycle clear pulse to the overflow flag |

## Verification
The in-line assertions check the following on every cycle:
- At most one clear is ever high.
- A clear appears only in the cycle after a read, and only for a source that was enabled and pending at the read edge.
- `vec` moves only on a read.
- A zero code coincides with no clear.

Some behaviour only the bench scenarios can show, because it depends on the stimulus:
- Each source producing its own code.
- The ranking between mixed combinations of sources.
- Disabled flags staying pending and silent.
- A flag raised during the clear cycle surviving to the next read.

// File: rtl/tmr_irq_vector.sv
module tmr_irq_vector #(
  parameter int NCH = 4,
  parameter int VW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_flag,
  input  logic [NCH-1:0] chan_en,
  input  logic           ovf_flag,
  input  logic           ovf_en,
  input  logic           rd_stb,
  output logic           irq,
  output logic [VW-1:0]  vec,
  output logic [NCH-1:0] chan_clr,
  output logic           ovf_clr
);

  localparam logic [VW-1:0] OVF_CODE = VW'(14);

  logic [NCH-1:0] chan_act;
  logic           ovf_act;
  logic [NCH-1:0] win_chan;
  logic           win_ovf;
  logic [VW-1:0]  win_code;

  assign chan_act = chan_flag & chan_en;
  assign ovf_act  = ovf_flag & ovf_en;
  assign irq      = (|chan_act) | ovf_act;

  always_comb begin
    win_chan = '0;
    win_ovf  = 1'b0;
    win_code = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (chan_act[i]) begin
        win_chan    = '0;
        win_chan[i] = 1'b1;
        win_code    = VW'(2 * (i + 1));
      end
    end
    if (chan_act == '0 && ovf_act) begin
      win_ovf  = 1'b1;
      win_code = OVF_CODE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec      <= '0;
      chan_clr <= '0;
      ovf_clr  <= 1'b0;
    end else if (rd_stb) begin
      vec      <= win_code;
      chan_clr <= win_chan;
      ovf_clr  <= win_ovf;
    end else begin
      chan_clr <= '0;
      ovf_clr  <= 1'b0;
    end
  end

  // R6: never more than one source retired
  assert_single_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_clr, chan_clr}));

  // R6: a clear only follows a sampled read
  assert_clear_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|{ovf_clr, chan_clr}) |-> $past(rd_stb));

  // R5: vector changes only on a read
  assert_vec_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(vec));

  // R4: empty code goes with no clear, and a nonzero code with one
  assert_zero_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_stb) |-> ((vec == '0) == ({ovf_clr, chan_clr} == '0)));

  // R2: the overflow clear only hits an enabled, pending overflow
  assert_ovf_clear_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clr |-> $past(ovf_flag && ovf_en));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R2: a channel clear only hits an enabled, pending channel
    assert_chan_clear_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
      chan_clr[g] |-> $past(chan_flag[g] && chan_en[g]));
  end

endmodule

// File: tb/tmr_irq_vector_tb.sv
module tmr_irq_vector_tb;
  localparam int NCH = 4;
  localparam int VW  = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic [NCH-1:0] chan_flag = '0;
  logic [NCH-1:0] chan_en = '0;
  logic ovf_flag = 0;
  logic ovf_en = 0;
  logic rd_stb = 0;
  logic irq;
  logic [VW-1:0] vec;
  logic [NCH-1:0] chan_clr;
  logic ovf_clr;

  int n_cmp = 0;
  int n_bad = 0;
  logic pend = 0;
  logic [VW+NCH:0] sb_q[$];
  string sb_tag[$];

  always #10 clk = ~clk;

  tmr_irq_vector #(.NCH(NCH), .VW(VW)) u_dut (
    .clk(clk), .rst_n(rst_n), .chan_flag(chan_flag), .chan_en(chan_en),
    .ovf_flag(ovf_flag), .ovf_en(ovf_en), .rd_stb(rd_stb), .irq(irq),
    .vec(vec), .chan_clr(chan_clr), .ovf_clr(ovf_clr));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [VW+NCH:0] model();
    logic [NCH-1:0] a;
    a = chan_flag & chan_en;
    for (int i = 0; i < NCH; i++)
      if (a[i]) return {VW'(2 * (i + 1)), 1'b0, NCH'(1 << i)};
    if (ovf_flag && ovf_en) return {VW'(14), 1'b1, NCH'(0)};
    return '0;
  endfunction

  always @(posedge clk) pend <= rd_stb;

  // monitor: compare the design against the scoreboard one cycle after each read
  initial forever begin
    @(negedge clk);
    if (pend) begin
      if (sb_q.size() == 0) check("R5 scoreboard empty", 1, 0);
      else begin
        logic [VW+NCH:0] e;
        string t;
        e = sb_q.pop_front();
        t = sb_tag.pop_front();
        check(t, {vec, ovf_clr, chan_clr}, e);
      end
    end
  end

  // driver: one read, then the flag owner clears the retired flag
  task automatic do_read(string tag);
    logic [VW+NCH:0] e;
    e = model();
    sb_q.push_back(e);
    sb_tag.push_back(tag);
    rd_stb = 1;
    @(negedge clk);
    rd_stb = 0;
    chan_flag &= ~e[NCH-1:0];
    if (e[NCH]) ovf_flag = 0;
    @(negedge clk);
    check({tag, " R6 pulse ends"}, {ovf_clr, chan_clr}, 0);
    check({tag, " R5 vec held"}, vec, e[VW+NCH:NCH+1]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset vec", vec, 0);
    check("R8 reset clr", {ovf_clr, chan_clr}, 0);
    rst_n = 1;
    @(negedge clk);
    check("R8 after reset vec", vec, 0);
    check("R1 idle irq", irq, 0);

    // R2: disabled flags stay silent and are not cleared
    chan_flag = 4'b1111; ovf_flag = 1;
    @(negedge clk);
    check("R2 disabled no irq", irq, 0);
    do_read("R2 disabled read empty R4");
    check("R2 disabled flags kept", {ovf_flag, chan_flag}, 5'h1F);
    chan_flag = 0; ovf_flag = 0;

    // R1/R4: each source alone
    chan_en = 4'hF; ovf_en = 1;
    for (int i = 0; i < NCH; i++) begin
      chan_flag[i] = 1;
      @(negedge clk);
      check("R1 single irq", irq, 1);
      do_read("R4 single channel code");
      check("R1 cleared irq", irq, 0);
    end
    ovf_flag = 1;
    @(negedge clk);
    check("R1 ovf irq", irq, 1);
    do_read("R4 ovf code");

    // R3/R9: all pending, drained in priority order
    chan_flag = 4'hF; ovf_flag = 1;
    for (int i = 0; i < 5; i++) begin
      do_read("R3 priority order");
      check("R9 irq while remaining", irq, i < 4);
    end
    do_read("R6 empty read no clear");

    // R3/R2: mixed pattern with enable gating
    chan_flag = 4'b1010; chan_en = 4'b1000; ovf_flag = 1;
    do_read("R3 masked ch2 skipped");
    check("R2 ch2 kept", chan_flag, 4'b0010);
    do_read("R3 ovf after ch4");
    chan_flag = 0; chan_en = 4'hF;

    // R7: flag raised after the sampling edge survives
    chan_flag = 4'b0100;
    sb_q.push_back(model()); sb_tag.push_back("R7 first read");
    rd_stb = 1;
    @(negedge clk);
    rd_stb = 0;
    chan_flag = 4'b0001;
    @(negedge clk);
    check("R7 late flag kept irq", irq, 1);
    do_read("R7 late flag wins next");

    repeat (3) @(negedge clk);
    check("R5 scoreboard drained", sb_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule